// File: doc/BRIEF.md
# 64-bit Timestamp Counter with Torn-Read Detection

This block keeps a 64-bit free-running cycle count and presents it to software through a small register interface whose data path is only 32 bits wide. A full sample therefore takes two reads. A carry from the lower word into the upper word can land between those two reads. If it does, the two halves come from different moments and the pair is "torn".

To make this visible, the first read (low word) copies the whole 64-bit count into a shadow register. The second read (high word) returns the upper half of that shadow. The upper word of the live count is then compared with the upper half captured in the shadow. If they differ, the pair is marked as torn.

Software reads the low word, then the high word, then the control register. Bit 31 of the control register reports whether the pair just read was consistent. Software repeats the three reads until that bit is 1. Bit 0 of the control register enables counting.

Top module: `stamp_counter`

## Requirements
- R1: A synchronous active-low reset loads the counter with the parameter START_VAL (zero by default) and clears the enable bit, the shadow register, the pair-pending state and the consistency bit. The read data output is cleared to zero.
- R2: A write to the control address (0x103) sets the enable bit from write-data bit 0. While the enable bit is 1, the counter rises by exactly one per clock. While the enable bit is 0, the counter holds its value. The new enable value first affects the count on the edge after the write edge.
- R3: A read of the low-word address (0x104) returns bits 31:0 of the count as it stood at the sampling edge. The data appears on the read data output one clock after the read request. The same read copies all 64 bits of that count into the shadow register.
- R4: A read of the high-word address (0x105) returns bits 63:32 of the shadow register. The counter may have advanced since the low-word read; the returned value is still the captured one.
- R5: A read of the control address returns the consistency bit in bit 31 and the enable bit in bit 0. Bits 30:1 read as zero.
- R6: The consistency bit becomes 1 on a high-word read when a low-word read preceded it (with no high-word read in between) and the live upper word still equals the shadow's upper word.
- R7: The consistency bit becomes 0 on a high-word read when the live upper word differs from the shadow's upper word. This is the case when a carry has crossed into the upper word since the low-word read.
- R8: The consistency bit becomes 0 on a high-word read that has no pending low-word read. A high-word read always ends the pending pair.
- R9: A low-word read clears the consistency bit. The bit stays 0 until the pair completes.
- R10: A request with the write strobe high is a write only, even when the read strobe is also high. Writes to any address other than control change nothing. Reads of unmapped addresses return zero.
- R11: In a cycle with no read request, the read data output keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; counter and registers update on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Register address of the current request |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after the read strobe |

## Verification
The counter is started a short distance below a lower-word carry, set by a START_VAL override. This lets the bench try the low/high/control sequence in three places: far from a carry while disabled, far from a carry while enabled, and with a carry deliberately left to cross between the two halves. Comparing these runs separates a correct shadow capture from a live read of the upper word. It also separates a real carry check from a flag that is always set. A high-word read with no prior low-word read, and a control read between the halves, show whether the pending-pair state is tracked or merely assumed. Writes to data addresses, reads of unmapped addresses and combined write/read strobes show that nothing outside the control write disturbs the count or the enable.

// File: rtl/stamp_pkg.sv
// Shared types for the timestamp counter.
// Assumes: nothing beyond IEEE 1800-2017.
package stamp_pkg;

    // Kind of register access decoded from one bus cycle
    typedef enum logic [2:0] {
        ACC_IDLE    = 3'd0,
        ACC_CTRL_WR = 3'd1,
        ACC_CTRL_RD = 3'd2,
        ACC_LO_RD   = 3'd3,
        ACC_HI_RD   = 3'd4,
        ACC_MISC_RD = 3'd5
    } acc_e;

endpackage

// File: rtl/stamp_decode.sv
// Turns one bus cycle (address plus strobes) into a single access kind.
// Assumes: the write strobe wins when both strobes are high; writes to any
// address other than control are dropped (reported as idle).
module stamp_decode
    import stamp_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter logic [11:0] CTRL_ADDR = 12'h103,
    parameter logic [11:0] LO_ADDR   = 12'h104,
    parameter logic [11:0] HI_ADDR   = 12'h105
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output acc_e              acc
);

    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] A_LO   = ADDR_W'(LO_ADDR);
    localparam logic [ADDR_W-1:0] A_HI   = ADDR_W'(HI_ADDR);

    // classify the current request
    always_comb begin
        acc = ACC_IDLE;
        if (wr) begin
            if (addr == A_CTRL) acc = ACC_CTRL_WR;
        end else if (rd) begin
            if      (addr == A_CTRL) acc = ACC_CTRL_RD;
            else if (addr == A_LO)   acc = ACC_LO_RD;
            else if (addr == A_HI)   acc = ACC_HI_RD;
            else                     acc = ACC_MISC_RD;
        end
    end

endmodule

// File: rtl/stamp_count.sv
// Free-running counter built from SEG_W-wide segments chained by carry.
// Each segment steps when the enable is high and every lower segment is all
// ones. Assumes CNT_W is a multiple of SEG_W.
module stamp_count #(
    parameter int              CNT_W     = 64,
    parameter int              SEG_W     = 32,
    parameter logic [CNT_W-1:0] START_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    output logic [CNT_W-1:0] cnt
);

    localparam int NSEG = CNT_W / SEG_W;

    logic [NSEG-1:0] step;
    logic [NSEG-1:0] full;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SEG_W-1:0] seg_q;

        // step this segment when enabled and all lower segments wrap
        always_ff @(posedge clk) begin
            if (!rst_n)       seg_q <= START_VAL[g*SEG_W +: SEG_W];
            else if (step[g]) seg_q <= seg_q + SEG_W'(1);
        end

        assign full[g] = &seg_q;
        assign cnt[g*SEG_W +: SEG_W] = seg_q;

        if (g == 0) begin : g_first
            assign step[g] = en;
        end else begin : g_rest
            assign step[g] = step[g-1] & full[g-1];
        end
    end

    // R2: enabled count advances by exactly one per clock
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> cnt == $past(cnt) + CNT_W'(1));

    // R2: disabled count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(cnt));

endmodule

// File: rtl/stamp_shadow.sv
// Shadow capture and torn-read detection.
// A low-word read copies the whole count into the shadow and opens a pair.
// A high-word read closes the pair and records whether the live upper word
// still matches the captured one. Assumes the count only rises, so an
// unchanged upper word means no carry crossed between the two halves.
module stamp_shadow
    import stamp_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int DATA_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  acc_e             acc,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] shadow,
    output logic             ok
);

    localparam int HI_LSB = CNT_W - DATA_W;

    logic              armed;
    logic [DATA_W-1:0] live_hi;
    logic [DATA_W-1:0] snap_hi;

    assign live_hi = cnt[HI_LSB +: DATA_W];
    assign snap_hi = shadow[HI_LSB +: DATA_W];

    // capture the full count on a low-word read
    always_ff @(posedge clk) begin
        if (!rst_n)                 shadow <= '0;
        else if (acc == ACC_LO_RD)  shadow <= cnt;
    end

    // track the open pair and the consistency verdict
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
            ok    <= 1'b0;
        end else if (acc == ACC_LO_RD) begin
            armed <= 1'b1;
            ok    <= 1'b0;
        end else if (acc == ACC_HI_RD) begin
            armed <= 1'b0;
            ok    <= armed && (live_hi == snap_hi);
        end
    end

    // R4: shadow changes only on a low-word read
    p_shadow_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc != ACC_LO_RD |=> $stable(shadow));

    // R7: a crossed carry leaves the pair marked torn
    p_carry_torn_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_HI_RD && live_hi != snap_hi) |=> !ok);

    // R8: a high read with no open pair is never consistent
    p_need_pair_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_HI_RD && !armed) |=> !ok && !armed);

    // R9: a low read opens a pair and withdraws the verdict
    p_low_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc == ACC_LO_RD |=> !ok && armed);

    // R6: a clean pair is reported as consistent
    p_clean_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_HI_RD && armed && live_hi == snap_hi) |=> ok);

endmodule

// File: rtl/stamp_counter.sv
// Top of the timestamp counter: register decode, enable bit, counter,
// shadow/consistency logic and the registered read-data path.
// Assumes CNT_W == 2*DATA_W and single-cycle read and write strobes.
module stamp_counter
    import stamp_pkg::*;
#(
    parameter int               ADDR_W    = 12,
    parameter int               DATA_W    = 32,
    parameter int               CNT_W     = 64,
    parameter logic [11:0]      CTRL_ADDR = 12'h103,
    parameter logic [11:0]      LO_ADDR   = 12'h104,
    parameter logic [11:0]      HI_ADDR   = 12'h105,
    parameter logic [CNT_W-1:0] START_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int HI_LSB = CNT_W - DATA_W;

    acc_e              acc;
    logic              en_q;
    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  shadow;
    logic              ok;
    logic [DATA_W-1:0] ctrl_word;
    logic [DATA_W-1:0] rdata_q;

    stamp_decode #(
        .ADDR_W   (ADDR_W),
        .CTRL_ADDR(CTRL_ADDR),
        .LO_ADDR  (LO_ADDR),
        .HI_ADDR  (HI_ADDR)
    ) u_dec (
        .addr(bus_addr),
        .wr  (bus_wr),
        .rd  (bus_rd),
        .acc (acc)
    );

    stamp_count #(
        .CNT_W    (CNT_W),
        .SEG_W    (DATA_W),
        .START_VAL(START_VAL)
    ) u_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en_q),
        .cnt  (cnt)
    );

    stamp_shadow #(
        .CNT_W (CNT_W),
        .DATA_W(DATA_W)
    ) u_shd (
        .clk   (clk),
        .rst_n (rst_n),
        .acc   (acc),
        .cnt   (cnt),
        .shadow(shadow),
        .ok    (ok)
    );

    // enable bit, loaded from bit 0 of a control write
    always_ff @(posedge clk) begin
        if (!rst_n)                   en_q <= 1'b0;
        else if (acc == ACC_CTRL_WR)  en_q <= bus_wdata[0];
    end

    assign ctrl_word = {ok, {(DATA_W-2){1'b0}}, en_q};

    // registered read data, held when no read occurs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else begin
            case (acc)
                ACC_CTRL_RD: rdata_q <= ctrl_word;
                ACC_LO_RD:   rdata_q <= cnt[DATA_W-1:0];
                ACC_HI_RD:   rdata_q <= shadow[HI_LSB +: DATA_W];
                ACC_MISC_RD: rdata_q <= '0;
                default:     rdata_q <= rdata_q;
            endcase
        end
    end

    assign bus_rdata = rdata_q;

    // R1: reset clears read data and the verdict
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> bus_rdata == '0 && !ok && !en_q);

    // R5: control read shows zero in the middle bits and the enable in bit 0
    p_ctrl_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        acc == ACC_CTRL_RD |=> bus_rdata[DATA_W-2:1] == '0
                               && bus_rdata[0] == $past(en_q));

    // R3: low read returns the low word of the count at the request edge
    p_low_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        acc == ACC_LO_RD |=> bus_rdata == $past(cnt[DATA_W-1:0]));

    // R11: without a read the output is held
    p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc == ACC_IDLE || acc == ACC_CTRL_WR) |=> $stable(bus_rdata));

    // R10: a write to a non-control address leaves the enable alone
    p_stray_wr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr != ADDR_W'(CTRL_ADDR)) |=> $stable(en_q));

endmodule

// File: tb/sim_stamp_counter.sv
// Bench for stamp_counter: behavioural reference model compared every clock,
// plus hand-computed checks for each requirement.
module sim_stamp_counter;

    localparam logic [63:0] START = 64'h0000_0000_FFFF_FFC0;
    localparam logic [11:0] A_CTRL = 12'h103;
    localparam logic [11:0] A_LO   = 12'h104;
    localparam logic [11:0] A_HI   = 12'h105;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    stamp_counter #(.START_VAL(START)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
    );

    // reference model state
    logic [63:0] m_cnt, m_sh;
    logic        m_en, m_arm, m_ok;
    logic [31:0] m_rd;

    always @(posedge clk) begin
        logic n_en;
        if (!rst_n) begin
            m_cnt = START; m_sh = '0; m_en = 0; m_arm = 0; m_ok = 0; m_rd = '0;
        end else begin
            n_en = m_en;
            if (bus_wr) begin
                if (bus_addr == A_CTRL) n_en = bus_wdata[0];
            end else if (bus_rd) begin
                if (bus_addr == A_CTRL) m_rd = {m_ok, 30'd0, m_en};
                else if (bus_addr == A_LO) begin
                    m_rd = m_cnt[31:0]; m_sh = m_cnt; m_arm = 1; m_ok = 0;
                end else if (bus_addr == A_HI) begin
                    m_rd = m_sh[63:32];
                    m_ok = m_arm && (m_cnt[63:32] == m_sh[63:32]);
                    m_arm = 0;
                end else m_rd = '0;
            end
            if (m_en) m_cnt = m_cnt + 64'd1;
            m_en = n_en;
        end
    end

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // per-clock comparison against the model (R3, R4, R11 and all reads)
    always @(negedge clk) begin
        if (rst_n && !done) chk("R11 model compare", bus_rdata, m_rd);
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic also_rd = 0);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = also_rd;
        @(negedge clk);
        bus_wr = 0; bus_rd = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1;
        @(negedge clk);
        bus_rd = 0;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        logic [31:0] v, w, lo1, lo2;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk("R1 rdata after reset", bus_rdata, 32'h0);
        rd(A_CTRL, v); chk("R1 control after reset", v, 32'h0);
        rd(A_LO, v);   chk("R1 low word holds START_VAL", v, 32'hFFFF_FFC0);
        rd(A_HI, v);   chk("R4 high word of shadow", v, 32'h0);
        rd(A_CTRL, v); chk("R6 clean pair while disabled", v, 32'h8000_0000);
        rd(A_LO, lo1); rd(A_LO, lo2);
        chk("R2 disabled counter holds", lo2, lo1);

        wr(A_CTRL, 32'h1);
        rd(A_LO, lo1); rd(A_LO, lo2);
        chk("R2 enabled counter steps by one", lo2 - lo1, 32'd1);
        rd(A_HI, v);   chk("R4 high word before carry", v, 32'h0);
        rd(A_CTRL, v); chk("R6 clean pair while enabled", v, 32'h8000_0001);
        rd(A_CTRL, v); chk("R5 control read does not disturb verdict", v, 32'h8000_0001);

        rd(A_LO, v);   idle(80);
        rd(A_HI, v);   chk("R4 high word is the captured one", v, 32'h0);
        rd(A_CTRL, v); chk("R7 carry between halves marks torn", v, 32'h0000_0001);

        rd(A_LO, v);   rd(A_HI, w);
        chk("R4 retry high word after carry", w, 32'h1);
        rd(A_CTRL, v); chk("R6 retry gives clean pair", v, 32'h8000_0001);

        rd(A_HI, v);   rd(A_CTRL, v);
        chk("R8 high read without low read", v, 32'h0000_0001);

        rd(A_LO, v);   rd(A_CTRL, v);
        chk("R9 low read clears verdict", v, 32'h0000_0001);
        rd(A_HI, v);   rd(A_CTRL, v);
        chk("R6 pair completes after control read in between", v, 32'h8000_0001);

        rd(A_LO, lo1); idle(5); rd(A_HI, w);
        chk("R4 shadow survives idle cycles", w, 32'h1);

        wr(A_LO, 32'h0); wr(A_HI, 32'hFFFF_FFFF); wr(12'h200, 32'h0);
        rd(A_CTRL, v); chk("R10 stray writes leave enable", v, 32'h8000_0001);
        rd(12'h200, v); chk("R10 unmapped read is zero", v, 32'h0);
        rd(A_LO, lo1); rd(A_LO, lo2);
        chk("R10 stray writes leave count stepping", lo2 - lo1, 32'd1);
        chk("R10 low word not overwritten", lo1[31:16], 16'h0000);

        rd(A_CTRL, v);
        wr(A_LO, 32'h0, 1'b1);
        chk("R10 write wins over read strobe", bus_rdata, v);
        idle(3);
        chk("R11 rdata held while idle", bus_rdata, v);

        wr(A_CTRL, 32'h0);
        rd(A_LO, lo1); idle(4); rd(A_LO, lo2);
        chk("R2 counter stops after disable", lo2, lo1);
        rd(A_CTRL, v); chk("R5 control shows disabled", v, 32'h0);

        idle(2);
        finish_run();
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

endmodule